// File: doc/BRIEF.md
# Unaligned Load Access Unit

This unit serves loads of 1, 2, 4 or 8 bytes at any byte address. On one side is a load port with a valid/ready request. On the other side is a little-endian memory that returns one naturally aligned 8-byte word for each read. The unit handles one load at a time.

When all requested bytes lie inside one aligned word, the unit makes one read. When they run past the end of that word, it makes two reads, one after the other: first the aligned word that holds the start address, then the next one. It keeps the first word and joins the two. It then picks out the requested bytes in address order, the lowest-addressed byte in the least significant position. The result is right-justified and zero-extended to 64 bits.

Memory latency may be any number of cycles. The unit issues a single-cycle read request and waits for the data strobe before it moves on.

Top module: `unaligned_load_unit`

## Requirements
- R1: After reset, reqReady is 1 and busy, rspValid and memReq are 0.
- R2: A request is taken only when reqValid and reqReady are both high at a clock edge. reqReady is low for the whole time a load is in progress. A reqValid held high during that time has no effect on the load in progress or on its memory reads.
- R3: reqSize encodes the load width: 0 means 1 byte, 1 means 2 bytes, 2 means 4 bytes and 3 means 8 bytes.
- R4: When (reqAddr mod 8) + width is at most 8, exactly one memory read is issued, at reqAddr with its low 3 bits cleared.
- R5: When (reqAddr mod 8) + width exceeds 8, exactly two reads are issued. The first is at the aligned base, the second at base + 8. The second is issued only after the data of the first has returned.
- R6: Result byte i (bits 8i+7..8i) equals the memory byte at address reqAddr + i. Memory byte k of a returned word sits in bits 8k+7..8k.
- R7: Result bytes at positions equal to or above the load width are zero.
- R8: rspValid is high for exactly one cycle per load, and rspData is zero whenever rspValid is low.
- R9: Each memory read is a one-cycle memReq pulse. The unit waits any number of cycles for memDataValid before it continues.
- R10: busy is high from the cycle after a request is taken through the cycle in which rspValid is high, and low after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Load request present |
| reqReady | output | 1 | Unit can take a request |
| reqAddr | input | ADDR_W | Byte address of the load |
| reqSize | input | 2 | Width code (0:1, 1:2, 2:4, 3:8 bytes) |
| memReq | output | 1 | One-cycle memory read request |
| memAddr | output | ADDR_W | Aligned word address for the read |
| memData | input | 64 | Returned memory word, little-endian |
| memDataValid | input | 1 | memData is valid this cycle |
| rspValid | output | 1 | Result is valid this cycle |
| rspData | output | 64 | Right-justified, zero-extended result |
| busy | output | 1 | A load is in progress |

## Verification
The bench runs every width code against every offset 0 to 7. It does this at a low aligned base and at a base near the top of the address space, so each case is either within one word or spanning two. A byte at each address is a distinct arithmetic function of that address, so a byte taken from the wrong lane or the wrong word shows up, and so does a wrong shift or a missing zero-fill. Memory latency changes from load to load, which tests that the unit waits for the strobe. On some loads reqValid stays high with a different address while the load is in progress; if that junk request were accepted, it would change the read count or the returned bytes.

// File: rtl/ldu_pkg.sv
package ldu_pkg;
  typedef enum logic [1:0] {
    ST_IDLE     = 2'd0,
    ST_FETCH_LO = 2'd1,
    ST_FETCH_HI = 2'd2,
    ST_REPLY    = 2'd3
  } ldu_state_e;

  // strobes from control to datapath
  typedef struct packed {
    logic accept;      // latch request fields
    logic captureLo;   // store first fetched word
    logic captureHi;   // store second fetched word
    logic selectNext;  // address the following aligned word
    logic reply;       // drive the assembled result
  } ldu_strobe_t;
endpackage

// File: rtl/ldu_ctrl.sv
module ldu_ctrl
  import ldu_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  output logic        reqReady,
  input  logic        memDataValid,
  input  logic        spansIn,
  output logic        memReq,
  output logic        rspValid,
  output logic        busy,
  output ldu_strobe_t strobes
);
  ldu_state_e state, stateNext;
  logic issued;
  logic [1:0] readCnt;

  always_comb begin
    strobes            = '0;
    strobes.accept     = (state == ST_IDLE) && reqValid;
    strobes.captureLo  = (state == ST_FETCH_LO) && issued && memDataValid;
    strobes.captureHi  = (state == ST_FETCH_HI) && issued && memDataValid;
    strobes.selectNext = (state == ST_FETCH_HI);
    strobes.reply      = (state == ST_REPLY);
  end

  assign reqReady = (state == ST_IDLE);
  assign busy     = (state != ST_IDLE);
  assign rspValid = strobes.reply;
  assign memReq   = ((state == ST_FETCH_LO) || (state == ST_FETCH_HI)) && !issued;

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE:     if (strobes.accept) stateNext = ST_FETCH_LO;
      ST_FETCH_LO: if (strobes.captureLo) stateNext = spansIn ? ST_FETCH_HI : ST_REPLY;
      ST_FETCH_HI: if (strobes.captureHi) stateNext = ST_REPLY;
      ST_REPLY:    stateNext = ST_IDLE;
      default:     stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      issued <= 1'b0;
    end else begin
      state <= stateNext;
      if (strobes.accept || strobes.captureLo || strobes.captureHi) issued <= 1'b0;
      else if (memReq) issued <= 1'b1;
    end
  end

  // read counter for the per-load read-count check
  always_ff @(posedge clk) begin
    if (!rstN) readCnt <= 2'd0;
    else if (strobes.accept) readCnt <= 2'd0;
    else if (memReq && readCnt != 2'd3) readCnt <= readCnt + 2'd1;
  end

  // R2
  accept_locks_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> (busy && !reqReady));

  // R8
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> !rspValid);

  // R9
  req_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReq |=> !memReq);

  // R4 R5
  read_count_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> (readCnt == (spansIn ? 2'd2 : 2'd1)));

  // R10
  busy_end_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> !busy);
endmodule

// File: rtl/ldu_datapath.sv
module ldu_datapath
  import ldu_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int WORD_BYTES = 8,
  parameter int SIZE_W     = 2
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  ldu_strobe_t             strobes,
  input  logic [ADDR_W-1:0]       reqAddr,
  input  logic [SIZE_W-1:0]       reqSize,
  input  logic [WORD_BYTES*8-1:0] memData,
  output logic [ADDR_W-1:0]       memAddr,
  output logic                    spansOut,
  output logic [WORD_BYTES*8-1:0] rspData
);
  localparam int DATA_W = WORD_BYTES * 8;
  localparam int OFFS_W = $clog2(WORD_BYTES);
  localparam int CNT_W  = OFFS_W + 2;
  localparam int SHA_W  = OFFS_W + 3;

  logic [ADDR_W-1:0] baseAddr;
  logic [OFFS_W-1:0] offs;
  logic [SIZE_W-1:0] sizeReg;
  logic [DATA_W-1:0] loWord, hiWord;
  logic [CNT_W-1:0]  nBytes;
  logic [2*DATA_W-1:0] window;
  logic [DATA_W-1:0] lowWin;
  logic [WORD_BYTES-1:0] laneOn;
  logic [ADDR_W-1:0] firstAddr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseAddr <= '0;
      offs     <= '0;
      sizeReg  <= '0;
      loWord   <= '0;
      hiWord   <= '0;
    end else begin
      if (strobes.accept) begin
        baseAddr <= {reqAddr[ADDR_W-1:OFFS_W], {OFFS_W{1'b0}}};
        offs     <= reqAddr[OFFS_W-1:0];
        sizeReg  <= reqSize;
        hiWord   <= '0;
      end
      if (strobes.captureLo) loWord <= memData;
      if (strobes.captureHi) hiWord <= memData;
    end
  end

  assign memAddr  = strobes.selectNext ? baseAddr + ADDR_W'(WORD_BYTES) : baseAddr;
  assign nBytes   = CNT_W'(1) << sizeReg;
  assign spansOut = ({2'b00, offs} + nBytes) > CNT_W'(WORD_BYTES);

  assign window = {hiWord, loWord};
  assign lowWin = DATA_W'(window >> {offs, 3'b000});

  for (genvar k = 0; k < WORD_BYTES; k++) begin : g_lane
    assign laneOn[k] = (CNT_W'(k) < nBytes);
    assign rspData[8*k +: 8] = (strobes.reply && laneOn[k]) ? lowWin[8*k +: 8] : 8'h00;
  end

  // address of the first read, kept for the second-read check
  always_ff @(posedge clk) begin
    if (!rstN) firstAddr <= '0;
    else if (strobes.captureLo) firstAddr <= memAddr;
  end

  // R5
  second_addr_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.captureHi |-> (memAddr - firstAddr == ADDR_W'(WORD_BYTES)));

  // R7
  upper_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.reply |-> ((rspData >> {nBytes, 3'b000}) == '0));

  // R8
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.reply |-> (rspData == '0));
endmodule

// File: rtl/unaligned_load_unit.sv
module unaligned_load_unit
  import ldu_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int WORD_BYTES = 8,
  localparam int SIZE_W    = $clog2($clog2(WORD_BYTES) + 1),
  localparam int DATA_W    = WORD_BYTES * 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [SIZE_W-1:0] reqSize,
  output logic              memReq,
  output logic [ADDR_W-1:0] memAddr,
  input  logic [DATA_W-1:0] memData,
  input  logic              memDataValid,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspData,
  output logic              busy
);
  ldu_strobe_t strobes;
  logic spans;

  ldu_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .memDataValid(memDataValid), .spansIn(spans), .memReq(memReq),
    .rspValid(rspValid), .busy(busy), .strobes(strobes)
  );

  ldu_datapath #(.ADDR_W(ADDR_W), .WORD_BYTES(WORD_BYTES), .SIZE_W(SIZE_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .reqAddr(reqAddr),
    .reqSize(reqSize), .memData(memData), .memAddr(memAddr),
    .spansOut(spans), .rspData(rspData)
  );
endmodule

// File: tb/unaligned_load_unit_tb.sv
`timescale 1ns/1ps
module unaligned_load_unit_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [31:0] reqAddr = '0;
  logic [1:0]  reqSize = '0;
  logic        memReq;
  logic [31:0] memAddr;
  logic [63:0] memData = '0;
  logic        memDataValid = 1'b0;
  logic        rspValid;
  logic [63:0] rspData;
  logic        busy;

  int checks = 0;
  int errors = 0;
  int memLat = 1;
  int pendCnt = 0;
  logic [31:0] pendAddr = '0;
  int readTotal = 0;
  logic [31:0] rdPrev = '0, rdLast = '0;
  int orderErr = 0, pulseErr = 0;
  logic prevReq = 1'b0;

  always #4 clk = ~clk;

  unaligned_load_unit u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqAddr(reqAddr), .reqSize(reqSize), .memReq(memReq), .memAddr(memAddr),
    .memData(memData), .memDataValid(memDataValid), .rspValid(rspValid),
    .rspData(rspData), .busy(busy)
  );

  function automatic logic [7:0] memByte(input logic [31:0] a);
    return (a[7:0] * 8'd37) ^ a[15:8] ^ a[31:24] ^ 8'h5A;
  endfunction

  function automatic logic [63:0] memWord(input logic [31:0] a);
    logic [63:0] w;
    for (int k = 0; k < 8; k++) w[8*k +: 8] = memByte(a + 32'(k));
    return w;
  endfunction

  // memory model and read monitor
  always @(posedge clk) begin
    memDataValid <= 1'b0;
    if (pendCnt != 0) begin
      pendCnt <= pendCnt - 1;
      if (pendCnt == 1) begin
        memDataValid <= 1'b1;
        memData      <= memWord(pendAddr);
      end
    end
    if (rstN && memReq) begin
      if (pendCnt != 0) orderErr <= orderErr + 1;
      if (prevReq) pulseErr <= pulseErr + 1;
      pendCnt   <= memLat;
      pendAddr  <= memAddr;
      rdPrev    <= rdLast;
      rdLast    <= memAddr;
      readTotal <= readTotal + 1;
    end
    prevReq <= memReq;
  end

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic doLoad(input logic [31:0] addr, input logic [1:0] size, input int lat, input bit holdJunk);
    int rb, ob, pb, cycles, nb, off;
    bit got;
    logic [63:0] exp, res;
    logic [31:0] base;
    @(negedge clk);
    memLat = lat;
    rb = readTotal; ob = orderErr; pb = pulseErr;
    reqValid = 1'b1; reqAddr = addr; reqSize = size;
    check(reqReady == 1'b1, "R2 ready in idle", 64'(reqReady), 64'd1);
    @(negedge clk);
    if (holdJunk) begin
      reqAddr = addr ^ 32'h0000_0055;
      reqSize = ~size;
    end else reqValid = 1'b0;
    cycles = 0; got = 0; res = '0;
    while (!got && cycles < 64) begin
      check(busy == 1'b1, "R10 busy during load", 64'(busy), 64'd1);
      check(reqReady == 1'b0, "R2 ready low while busy", 64'(reqReady), 64'd0);
      if (rspValid) begin
        got = 1; res = rspData;
      end else begin
        check(rspData == '0, "R8 data zero without valid", rspData, 64'd0);
        @(negedge clk);
        cycles++;
      end
    end
    reqValid = 1'b0;
    check(got, "R9 response arrives", 64'(got), 64'd1);
    // R3 width code, R6 byte order, R7 zero fill
    nb = 1 << size;
    exp = '0;
    for (int i = 0; i < nb; i++) exp[8*i +: 8] = memByte(addr + 32'(i));
    check(res == exp, $sformatf("R6 R7 R3 data addr=%h size=%0d", addr, size), res, exp);
    @(negedge clk);
    check(rspValid == 1'b0, "R8 valid single cycle", 64'(rspValid), 64'd0);
    check(rspData == '0, "R8 data zero after reply", rspData, 64'd0);
    check(busy == 1'b0, "R10 busy cleared", 64'(busy), 64'd0);
    off  = int'(addr[2:0]);
    base = {addr[31:3], 3'b000};
    if (off + nb > 8) begin
      check(readTotal - rb == 2, "R5 two reads", 64'(readTotal - rb), 64'd2);
      check(rdPrev == base, "R5 first read address", 64'(rdPrev), 64'(base));
      check(rdLast == base + 32'd8, "R5 second read address", 64'(rdLast), 64'(base + 32'd8));
      check(orderErr == ob, "R5 second read after first data", 64'(orderErr - ob), 64'd0);
    end else begin
      check(readTotal - rb == 1, "R4 one read", 64'(readTotal - rb), 64'd1);
      check(rdLast == base, "R4 read address", 64'(rdLast), 64'(base));
    end
    check(pulseErr == pb, "R9 request pulse width", 64'(pulseErr - pb), 64'd0);
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] bases [3];
    bases[0] = 32'h0000_0000;
    bases[1] = 32'h0000_1238;
    bases[2] = 32'hFFFF_FFF0;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(reqReady == 1'b1, "R1 reqReady", 64'(reqReady), 64'd1);
    check(busy == 1'b0, "R1 busy", 64'(busy), 64'd0);
    check(rspValid == 1'b0, "R1 rspValid", 64'(rspValid), 64'd0);
    check(memReq == 1'b0, "R1 memReq", 64'(memReq), 64'd0);
    for (int b = 0; b < 3; b++)
      for (int s = 0; s < 4; s++)
        for (int o = 0; o < 8; o++)
          doLoad(bases[b] + 32'(o), 2'(s), 1 + ((o + s + b) % 4), ((o + s) % 3) == 0);
    repeat (3) @(negedge clk);
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule